// File: doc/BRIEF.md
# Programmable Square-Wave Output Generator

This block turns a 32.768 kHz reference into a selectable square wave for a calendar-clock device. It also supplies the once-per-second tick that advances the time counters. The reference arrives as a level signal that is synchronous to the system clock. A free-running binary prescaler counts the reference's rising edges. A two-bit rate field picks the output: the prescaler's top bit, one of two low prescaler bits, or the reference level itself. A single 8-bit control byte holds the rate field, an enable bit and a static level bit. The byte is written and read through a small address/data port.

When the enable bit is clear, the output pin carries the static level. The seconds tick is a one-cycle pulse issued every time the prescaler wraps. It is issued whatever the enable bit and rate field hold. The wrap moves the top prescaler bit from one to zero, so the counters advance on the falling edge of the slowest square wave. A rate change does not restart the prescaler, so the output may show one shortened phase when the rate changes.

Top module: `sqw_gen`

## Requirements
- R1: After reset the control byte reads 03h, `sq_out` is 0 and `sec_tick` is 0.
- R2: A write to address `CTRL_ADDR` keeps only bit 7 (static level), bit 4 (enable) and bits 1:0 (rate). All other bits read back as 0. `rd_data` is 0 at any other address.
- R3: A write to any address other than `CTRL_ADDR` leaves the control byte and `sq_out` unchanged.
- R4: With bit 4 clear, `sq_out` equals bit 7.
- R5: With bit 4 set and rate 00, `sq_out` equals bit `DIV_W-1` of the count of reference rising edges since reset, taken modulo 2^DIV_W. This is the 1 Hz output at the default width, with a 50 % duty cycle.
- R6: With bit 4 set and rate 01, `sq_out` equals bit 2 of that count. This gives a period of 8 reference cycles (4.096 kHz).
- R7: With bit 4 set and rate 10, `sq_out` equals bit 1 of that count. This gives a period of 4 reference cycles (8.192 kHz).
- R8: With bit 4 set and rate 11, `sq_out` follows the reference level one clock late when `SYNC_REF` is 0.
- R9: `sec_tick` is high for exactly one clock after each reference rising edge that brings the count to a multiple of 2^DIV_W. The enable bit and the rate field do not affect it.
- R10: When rate 00 is enabled, every `sec_tick` falls in the same cycle as a 1-to-0 step of `sq_out`.
- R11: Writing the control byte never restarts the prescaler, so tick spacing is unchanged across rate changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_lvl | input | 1 | 32.768 kHz reference level, synchronous to `clk` |
| wr_en | input | 1 | Write strobe for the control byte |
| addr | input | ADDR_W | Register address; `CTRL_ADDR` selects the control byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Control byte when `addr` matches, else 0 |
| sq_out | output | 1 | Square-wave or static-level output |
| sec_tick | output | 1 | One-cycle pulse on each prescaler wrap |

## Verification
The bench builds the block with `DIV_W` = 5 and `SYNC_REF` = 0, so the slowest output repeats every 32 reference edges instead of 32768. Several full periods and several prescaler wraps therefore fit in a short run. Every rate, both levels of the static bit, reserved-bit masking and rate changes in the middle of a period can all be reached at this size. Keeping `SYNC_REF` at 0 gives the fixed one-clock lag that the reference-rate check relies on.

// File: rtl/sqw_pkg.sv
package sqw_pkg;
   typedef enum logic [1:0] {
      RATE_SLOW = 2'b00,
      RATE_MID  = 2'b01,
      RATE_FAST = 2'b10,
      RATE_REF  = 2'b11
   } rate_e;

   typedef struct packed {
      logic       lvl;
      logic [1:0] rsv_hi;
      logic       en;
      logic [1:0] rsv_lo;
      rate_e      rate;
   } ctrl_t;

   localparam logic [7:0] CTRL_RESET = 8'h03;
   localparam logic [7:0] CTRL_WMASK = 8'h93;
   localparam int         TAP_MID    = 2;
   localparam int         TAP_FAST   = 1;
endpackage

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
   import sqw_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int CTRL_ADDR = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   output ctrl_t             ctrl_o,
   output logic [7:0]        rd_data
);
   localparam logic [ADDR_W-1:0] SEL = ADDR_W'(CTRL_ADDR);

   logic [7:0] ctrl_q;
   logic       hit;

   assign hit = (addr == SEL);

   always_ff @(posedge clk) begin
      if (!rst_n)
         ctrl_q <= CTRL_RESET;
      else if (wr_en && hit)
         ctrl_q <= wr_data & CTRL_WMASK;
   end

   assign ctrl_o  = ctrl_t'(ctrl_q);
   assign rd_data = hit ? ctrl_q : 8'h00;
endmodule

// File: rtl/sqw_prescaler.sv
module sqw_prescaler
   import sqw_pkg::*;
#(
   parameter int DIV_W    = 15,
   parameter bit SYNC_REF = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ref_lvl,
   output logic       ref_o,
   output logic [2:0] taps_o,
   output logic       tick_o
);
   localparam int MSB = DIV_W - 1;

   logic             ref_in;
   logic             ref_q;
   logic             rise;
   logic [DIV_W-1:0] cnt_q;
   logic             tick_q;

   generate
      if (DIV_W < 4) begin : g_bad_width
         $error("sqw_prescaler: DIV_W must be at least 4");
      end
      if (SYNC_REF) begin : g_sync
         logic [1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= 2'b00;
            else        sync_q <= {sync_q[0], ref_lvl};
         end
         assign ref_in = sync_q[1];
      end else begin : g_direct
         assign ref_in = ref_lvl;
      end
   endgenerate

   assign rise = ref_in & ~ref_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ref_q  <= 1'b0;
         cnt_q  <= '0;
         tick_q <= 1'b0;
      end else begin
         ref_q  <= ref_in;
         tick_q <= rise && (&cnt_q);
         if (rise)
            cnt_q <= cnt_q + 1'b1;
      end
   end

   assign ref_o  = ref_q;
   assign taps_o = {cnt_q[MSB], cnt_q[TAP_MID], cnt_q[TAP_FAST]};
   assign tick_o = tick_q;
endmodule

// File: rtl/sqw_rate_mux.sv
module sqw_rate_mux
   import sqw_pkg::*;
(
   input  logic       en,
   input  logic       lvl,
   input  rate_e      rate,
   input  logic       ref_s,
   input  logic [2:0] taps,
   output logic       sq_o
);
   logic tap;

   always_comb begin
      unique case (rate)
         RATE_SLOW: tap = taps[2];
         RATE_MID:  tap = taps[1];
         RATE_FAST: tap = taps[0];
         default:   tap = ref_s;
      endcase
      sq_o = en ? tap : lvl;
   end
endmodule

// File: rtl/sqw_gen.sv
module sqw_gen
   import sqw_pkg::*;
#(
   parameter int ADDR_W    = 6,
   parameter int CTRL_ADDR = 7,
   parameter int DIV_W     = 15,
   parameter bit SYNC_REF  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_lvl,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [7:0]        wr_data,
   output logic [7:0]        rd_data,
   output logic              sq_out,
   output logic              sec_tick
);
   generate
      if (ADDR_W < 1 || CTRL_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("sqw_gen: CTRL_ADDR does not fit in ADDR_W bits");
      end
   endgenerate

   ctrl_t      ctrl_q;
   logic [7:0] ctrl_bits;
   logic       ref_s;
   logic [2:0] taps;

   assign ctrl_bits = ctrl_q;

   sqw_ctrl_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_reg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .ctrl_o(ctrl_q), .rd_data(rd_data)
   );

   sqw_prescaler #(.DIV_W(DIV_W), .SYNC_REF(SYNC_REF)) u_div (
      .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl),
      .ref_o(ref_s), .taps_o(taps), .tick_o(sec_tick)
   );

   sqw_rate_mux u_mux (
      .en(ctrl_q.en), .lvl(ctrl_q.lvl), .rate(ctrl_q.rate),
      .ref_s(ref_s), .taps(taps), .sq_o(sq_out)
   );
endmodule

// File: rtl/sqw_gen_chk.sv
module sqw_gen_chk #(
   parameter int ADDR_W    = 6,
   parameter int CTRL_ADDR = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [ADDR_W-1:0] addr,
   input logic [7:0]        ctrl,
   input logic              ref_s,
   input logic              sq_out,
   input logic              sec_tick
);
   logic armed;
   always_ff @(posedge clk) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl & 8'h6C) == 8'h00);                                        // R2
   AST_FOREIGN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      armed && wr_en && (addr != ADDR_W'(CTRL_ADDR)) |=> $stable(ctrl)); // R3
   AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl[4] |-> (sq_out == ctrl[7]));                               // R4
   AST_REF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl[4] && (ctrl[1:0] == 2'b11) |-> (sq_out == ref_s));          // R8
   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      armed && sec_tick |=> !sec_tick);                                // R9
   AST_TICK_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      armed && sec_tick && ctrl[4] && (ctrl[1:0] == 2'b00) && $stable(ctrl)
      |-> $fell(sq_out));                                              // R10
endmodule

bind sqw_gen sqw_gen_chk #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
   .ctrl(ctrl_bits), .ref_s(ref_s), .sq_out(sq_out), .sec_tick(sec_tick)
);

// File: tb/sim_sqw_gen.sv
module sim_sqw_gen;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 6;
   localparam int CTRL_ADDR  = 7;
   localparam int DIV_W      = 5;
   localparam int WRAP       = 1 << DIV_W;
   localparam int HALF       = 4;
   localparam int NVEC       = 10;
   // {control byte written, reference cycles to run}
   localparam logic [15:0] VEC [NVEC] = '{
      16'h1046, 16'h1114, 16'h120C, 16'h1306, 16'h8005,
      16'h0005, 16'h9306, 16'hFF06, 16'h6D05, 16'h1C28
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ref_lvl = 1'b0;
   logic              wr_en = 1'b0;
   logic [ADDR_W-1:0] addr = ADDR_W'(CTRL_ADDR);
   logic [7:0]        wr_data = 8'h00;
   logic [7:0]        rd_data;
   logic              sq_out;
   logic              sec_tick;

   int         checks = 0;
   int         errors = 0;
   int         refcnt = 0;
   int         cycles = 0;
   bit         done = 1'b0;
   logic [7:0] m_ctrl = 8'h03;
   logic       prev_sq = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sqw_gen #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .DIV_W(DIV_W), .SYNC_REF(1'b0)) u0 (
      .clk(clk), .rst_n(rst_n), .ref_lvl(ref_lvl), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .sq_out(sq_out), .sec_tick(sec_tick)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000 && !done) begin
         errors = errors + 1;
         $display("FAIL R1 watchdog expired actual=%0d expected=<20000", cycles);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (ref edges %0d)", tag, act, exp, refcnt);
      end
   endtask

   function automatic logic exp_sq(input logic [7:0] c, input logic lvl, input int n);
      if (!c[4]) return c[7];
      case (c[1:0])
         2'b00:   return 1'((n % WRAP) >> (DIV_W - 1));
         2'b01:   return 1'(n >> 2);
         2'b10:   return 1'(n >> 1);
         default: return lvl;
      endcase
   endfunction

   function automatic string sq_tag(input logic [7:0] c);
      if (!c[4]) return "R4 static level";
      case (c[1:0])
         2'b00:   return "R5 slow rate";
         2'b01:   return "R6 rate 01";
         2'b10:   return "R7 rate 10";
         default: return "R8 reference rate";
      endcase
   endfunction

   task automatic ref_phase(input logic lvl);
      bit  first = 1'b1;
      logic e_tick;
      logic e_sq;
      ref_lvl = lvl;
      if (lvl) refcnt++;
      repeat (HALF) begin
         @(negedge clk);
         e_sq   = exp_sq(m_ctrl, lvl, refcnt);
         e_tick = first && lvl && ((refcnt % WRAP) == 0);
         chk(sq_out == e_sq, sq_tag(m_ctrl), {7'd0, sq_out}, {7'd0, e_sq});
         chk(sec_tick == e_tick, "R9 R11 tick", {7'd0, sec_tick}, {7'd0, e_tick});
         if (e_tick && m_ctrl[4] && m_ctrl[1:0] == 2'b00)
            chk(prev_sq && !sq_out, "R10 tick on falling edge",
                {6'd0, prev_sq, sq_out}, 8'h02);
         prev_sq = sq_out;
         first = 1'b0;
      end
   endtask

   task automatic run_refs(input int n);
      for (int i = 0; i < n; i++) begin
         ref_phase(1'b1);
         ref_phase(1'b0);
      end
   endtask

   task automatic wr(input logic [ADDR_W-1:0] a, input logic [7:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; addr = ADDR_W'(CTRL_ADDR);
      if (a == ADDR_W'(CTRL_ADDR)) m_ctrl = d & 8'h93;
      prev_sq = sq_out;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; ref_lvl = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      refcnt = 0; m_ctrl = 8'h03;
      @(negedge clk);
      chk(rd_data == 8'h03, "R1 reset control byte", rd_data, 8'h03);
      chk(sq_out == 1'b0, "R1 reset output", {7'd0, sq_out}, 8'h00);
      chk(sec_tick == 1'b0, "R1 reset tick", {7'd0, sec_tick}, 8'h00);
      prev_sq = sq_out;
   endtask

   initial begin
      logic       keep_sq;
      logic [7:0] keep_ctrl;
      @(negedge clk);
      do_reset();

      // vector table walk
      for (int v = 0; v < NVEC; v++) begin
         wr(ADDR_W'(CTRL_ADDR), VEC[v][15:8]);
         chk(rd_data == (VEC[v][15:8] & 8'h93), "R2 readback mask",
             rd_data, VEC[v][15:8] & 8'h93);
         run_refs(int'(VEC[v][7:0]));
      end

      // rate changes mid-period, prescaler keeps counting
      wr(ADDR_W'(CTRL_ADDR), 8'h11);
      run_refs(3);
      wr(ADDR_W'(CTRL_ADDR), 8'h12);
      run_refs(5);
      wr(ADDR_W'(CTRL_ADDR), 8'h10);
      run_refs(WRAP + 4);

      // foreign address: no effect, reads as zero
      keep_ctrl = m_ctrl;
      keep_sq   = sq_out;
      wr(ADDR_W'(5), 8'h00);
      chk(sq_out == keep_sq, "R3 output after foreign write", {7'd0, sq_out}, {7'd0, keep_sq});
      addr = ADDR_W'(5);
      #1;
      chk(rd_data == 8'h00, "R2 foreign address reads zero", rd_data, 8'h00);
      addr = ADDR_W'(CTRL_ADDR);
      #1;
      chk(rd_data == keep_ctrl, "R3 control byte after foreign write", rd_data, keep_ctrl);
      run_refs(3);

      // reset in the middle of a run restarts everything
      do_reset();
      wr(ADDR_W'(CTRL_ADDR), 8'h10);
      run_refs(WRAP + 2);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule